// File: doc/BRIEF.md
# Modem Line Control and Status Unit

This unit sits beside the character engines of an asynchronous serial port and owns the handshake lines toward a modem. Software writes a small control register to drive four modem outputs, and to switch on an internal loopback path. It reads a status byte that reports the present level of four modem inputs, plus one change flag for each input. The change flags stay set until the status byte is read. Any pending flag raises a request toward the port's interrupt logic.

The same unit gates the port's interrupt line toward the host, using one of the control bits. In loopback mode the transmit serial stream is fed straight back into the receiver, and the external lines are left idle. The four status inputs are then taken from the control bits instead of the pins, so software can test the whole path without a cable.

The modem inputs are asynchronous. They pass through a synchroniser of `SYNC_STAGES` flops, and then a level register, before they appear in the status byte.

Top module: `modem_line_ctl`

## Requirements
- R1: A write stores control bits 4..0 (bit0 terminal-ready, bit1 request-to-send, bit2 aux-out-1, bit3 aux-out-2, bit4 loopback). The readback shows them in the next cycle, with bits 7..5 always zero. Reset clears all of them.
- R2: With loopback off, the outputs `mdm_dtr`, `mdm_rts`, `mdm_aux1` and `mdm_aux2` follow control bits 0, 1, 2 and 3.
- R3: `host_irq` equals `port_irq` AND control bit 3, in both modes.
- R4: Status bits 7..4 report the carrier-detect, ring, set-ready and clear-to-send levels, in that order. With loopback off, a pin change shows there `SYNC_STAGES+1` clock edges after it is sampled. Reset clears the status byte.
- R5: Status bits 3 (carrier-detect), 1 (set-ready) and 0 (clear-to-send) are change flags that set on any change of their level. Each flag stays set until a status read.
- R6: Status bit 2, the ring change flag, sets only when the ring level goes from 1 to 0. A rise of the ring level leaves it clear.
- R7: A status read clears all change flags at the clock edge where `sts_rd` is high. A level change that lands on that same edge still sets its flag.
- R8: `msc_req` is high exactly when any of status bits 3..0 is set.
- R9: With loopback on, the status levels come from the control bits one edge after the control register holds them: clear-to-send from bit 1, set-ready from bit 0, ring from bit 2, carrier-detect from bit 3. The modem input pins then have no effect on the status byte.
- R10: With loopback on, `ser_txd` is held at 1, the four modem outputs are 0, and `rx_ser` follows `tx_ser`. With loopback off, `ser_txd` follows `tx_ser` and `rx_ser` follows `ser_rxd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | BUS_W | Control write data |
| ctl_rdata | output | BUS_W | Control register readback |
| sts_rd | input | 1 | Status read strobe; clears change flags |
| sts_rdata | output | BUS_W | Status byte: levels 7..4, change flags 3..0 |
| msc_req | output | 1 | Modem status change request |
| port_irq | input | 1 | Raw interrupt from the port's prioritiser |
| host_irq | output | 1 | Interrupt toward the host, gated by aux-out-2 |
| mdm_cts | input | 1 | Clear-to-send pin, active high |
| mdm_dsr | input | 1 | Data-set-ready pin, active high |
| mdm_ri | input | 1 | Ring pin, active high |
| mdm_dcd | input | 1 | Carrier-detect pin, active high |
| mdm_dtr | output | 1 | Terminal-ready pin |
| mdm_rts | output | 1 | Request-to-send pin |
| mdm_aux1 | output | 1 | Auxiliary output 1 |
| mdm_aux2 | output | 1 | Auxiliary output 2 |
| tx_ser | input | 1 | Serial stream from the transmit shifter |
| ser_txd | output | 1 | External serial output |
| ser_rxd | input | 1 | External serial input |
| rx_ser | output | 1 | Serial stream to the receive shifter |

## Verification
The assertions assume that `sts_rd` is a single-cycle strobe, issued only when software reads the status byte. They also assume that the modem pins hold each new level for longer than the synchroniser depth, so that every pin change reaches the level register as one clean step. The stimulus changes at most one source of level at a time, and then waits until the change has settled. The one exception is the case that deliberately lines up a change with a read edge. Pins are driven on the falling clock edge, so every transition is sampled cleanly.

// File: rtl/mdm_pkg.sv
package mdm_pkg;

    // Order matches status bits 7..4 and change flags 3..0
    typedef struct packed {
        logic dcd;
        logic ri;
        logic dsr;
        logic cts;
    } mdm_lvl_t;

    // Order matches control bits 4..0
    typedef struct packed {
        logic loop_en;
        logic aux2;
        logic aux1;
        logic rts;
        logic dtr;
    } mdm_ctl_t;

    localparam int unsigned LVL_W = $bits(mdm_lvl_t);
    localparam int unsigned CTL_W = $bits(mdm_ctl_t);

    typedef struct packed {
        mdm_lvl_t         lvl;
        logic [LVL_W-1:0] dlt;
    } mdm_sts_t;

    localparam int unsigned STS_W = $bits(mdm_sts_t);

endpackage

// File: rtl/mdm_sync.sv
module mdm_sync #(
    parameter int unsigned WIDTH  = 4,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] stg_d [STAGES];
    logic [WIDTH-1:0] stg_q [STAGES];

    always_comb begin
        stg_d[0] = din;
        for (int i = 1; i < int'(STAGES); i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    generate
        for (genvar g = 0; g < int'(STAGES); g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q[g] <= '0;
                else        stg_q[g] <= stg_d[g];
            end
        end
    endgenerate

    assign dout = stg_q[STAGES-1];

endmodule

// File: rtl/mdm_ctl_reg.sv
module mdm_ctl_reg
    import mdm_pkg::*;
#(
    parameter int unsigned BUS_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_wr,
    input  logic [BUS_W-1:0] ctl_wdata,
    output logic [BUS_W-1:0] ctl_rdata,
    output mdm_ctl_t         ctl,
    input  logic             port_irq,
    output logic             host_irq,
    output logic             mdm_dtr,
    output logic             mdm_rts,
    output logic             mdm_aux1,
    output logic             mdm_aux2,
    input  logic             tx_ser,
    output logic             ser_txd,
    input  logic             ser_rxd,
    output logic             rx_ser
);

    localparam int unsigned PAD_W = BUS_W - CTL_W;

    mdm_ctl_t ctl_d, ctl_q;
    logic     unused_hi;

    assign unused_hi = ^ctl_wdata[BUS_W-1:CTL_W];

    always_comb begin
        ctl_d = ctl_q;
        if (ctl_wr) ctl_d = mdm_ctl_t'(ctl_wdata[CTL_W-1:0]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign ctl       = ctl_q;
    assign ctl_rdata = {{PAD_W{1'b0}}, ctl_q};
    assign host_irq  = port_irq & ctl_q.aux2;

    always_comb begin
        if (ctl_q.loop_en) begin
            mdm_dtr  = 1'b0;
            mdm_rts  = 1'b0;
            mdm_aux1 = 1'b0;
            mdm_aux2 = 1'b0;
            ser_txd  = 1'b1;
            rx_ser   = tx_ser;
        end else begin
            mdm_dtr  = ctl_q.dtr;
            mdm_rts  = ctl_q.rts;
            mdm_aux1 = ctl_q.aux1;
            mdm_aux2 = ctl_q.aux2;
            ser_txd  = tx_ser;
            rx_ser   = ser_rxd;
        end
    end

    // R1
    wr_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr |=> ctl_rdata[CTL_W-1:0] == $past(ctl_wdata[CTL_W-1:0]));

    // R1
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_wr |=> $stable(ctl_rdata));

endmodule

// File: rtl/mdm_status.sv
module mdm_status
    import mdm_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  mdm_lvl_t pin_lvl,
    input  mdm_ctl_t ctl,
    input  logic     sts_rd,
    output mdm_sts_t sts,
    output logic     msc_req
);

    mdm_sts_t         st_d, st_q;
    mdm_lvl_t         sel;
    logic [LVL_W-1:0] chg;

    always_comb begin
        if (ctl.loop_en) begin
            sel.cts = ctl.rts;
            sel.dsr = ctl.dtr;
            sel.ri  = ctl.aux1;
            sel.dcd = ctl.aux2;
        end else begin
            sel = pin_lvl;
        end
        chg = {sel.dcd ^ st_q.lvl.dcd,
               st_q.lvl.ri & ~sel.ri,
               sel.dsr ^ st_q.lvl.dsr,
               sel.cts ^ st_q.lvl.cts};
        st_d.lvl = sel;
        st_d.dlt = (sts_rd ? '0 : st_q.dlt) | chg;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sts     = st_q;
    assign msc_req = |st_q.dlt;

    // R5
    sticky_cts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.dlt[0] && !sts_rd |=> st_q.dlt[0]);

    // R6
    ri_trail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.dlt[2]) |-> $fell(st_q.lvl.ri));

    // R7
    rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sts_rd && (sel == st_q.lvl) |=> st_q.dlt == '0);

    // R9
    loop_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.loop_en |=> (st_q.lvl.cts == $past(ctl.rts)) && (st_q.lvl.dsr == $past(ctl.dtr))
                     && (st_q.lvl.ri == $past(ctl.aux1)) && (st_q.lvl.dcd == $past(ctl.aux2)));

endmodule

// File: rtl/modem_line_ctl.sv
module modem_line_ctl
    import mdm_pkg::*;
#(
    parameter int unsigned BUS_W       = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_wr,
    input  logic [BUS_W-1:0] ctl_wdata,
    output logic [BUS_W-1:0] ctl_rdata,
    input  logic             sts_rd,
    output logic [BUS_W-1:0] sts_rdata,
    output logic             msc_req,
    input  logic             port_irq,
    output logic             host_irq,
    input  logic             mdm_cts,
    input  logic             mdm_dsr,
    input  logic             mdm_ri,
    input  logic             mdm_dcd,
    output logic             mdm_dtr,
    output logic             mdm_rts,
    output logic             mdm_aux1,
    output logic             mdm_aux2,
    input  logic             tx_ser,
    output logic             ser_txd,
    input  logic             ser_rxd,
    output logic             rx_ser
);

    localparam int unsigned STS_PAD = BUS_W - STS_W;

    mdm_ctl_t         ctl;
    mdm_sts_t         sts;
    logic [LVL_W-1:0] pin_raw, pin_syn;

    assign pin_raw = {mdm_dcd, mdm_ri, mdm_dsr, mdm_cts};

    mdm_sync #(.WIDTH(LVL_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pin_raw),
        .dout (pin_syn)
    );

    mdm_ctl_reg #(.BUS_W(BUS_W)) u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctl_wr   (ctl_wr),
        .ctl_wdata(ctl_wdata),
        .ctl_rdata(ctl_rdata),
        .ctl      (ctl),
        .port_irq (port_irq),
        .host_irq (host_irq),
        .mdm_dtr  (mdm_dtr),
        .mdm_rts  (mdm_rts),
        .mdm_aux1 (mdm_aux1),
        .mdm_aux2 (mdm_aux2),
        .tx_ser   (tx_ser),
        .ser_txd  (ser_txd),
        .ser_rxd  (ser_rxd),
        .rx_ser   (rx_ser)
    );

    mdm_status u_sts (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_lvl(mdm_lvl_t'(pin_syn)),
        .ctl    (ctl),
        .sts_rd (sts_rd),
        .sts    (sts),
        .msc_req(msc_req)
    );

    assign sts_rdata = {{STS_PAD{1'b0}}, sts};

    // R8
    req_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        msc_req == (sts_rdata[LVL_W-1:0] != '0));

    // R10
    loop_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_rdata[4] |-> ser_txd && (rx_ser == tx_ser)
                         && !mdm_dtr && !mdm_rts && !mdm_aux1 && !mdm_aux2);

    // R3
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_irq |-> port_irq && ctl_rdata[3]);

endmodule

// File: tb/modem_line_ctl_bench.sv
module modem_line_ctl_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_wr = 1'b0;
    logic [7:0] ctl_wdata = '0;
    logic [7:0] ctl_rdata;
    logic       sts_rd = 1'b0;
    logic [7:0] sts_rdata;
    logic       msc_req, port_irq = 1'b0, host_irq;
    logic [3:0] pins = '0;          // {dcd, ri, dsr, cts}
    logic       mdm_dtr, mdm_rts, mdm_aux1, mdm_aux2;
    logic       tx_ser = 1'b1, ser_txd, ser_rxd = 1'b1, rx_ser;

    int checks = 0;
    int errors = 0;

    // Model state
    logic [4:0] m_ctl = '0;
    logic [3:0] m_lvl = '0;
    logic [3:0] m_dlt = '0;

    logic [7:0] exp_q [$];
    string      tag_q [$];

    always #2 clk = ~clk;

    modem_line_ctl u_modem_line_ctl (
        .clk(clk), .rst_n(rst_n),
        .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
        .sts_rd(sts_rd), .sts_rdata(sts_rdata), .msc_req(msc_req),
        .port_irq(port_irq), .host_irq(host_irq),
        .mdm_cts(pins[0]), .mdm_dsr(pins[1]), .mdm_ri(pins[2]), .mdm_dcd(pins[3]),
        .mdm_dtr(mdm_dtr), .mdm_rts(mdm_rts), .mdm_aux1(mdm_aux1), .mdm_aux2(mdm_aux2),
        .tx_ser(tx_ser), .ser_txd(ser_txd), .ser_rxd(ser_rxd), .rx_ser(rx_ser)
    );

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] eff_lvl();
        if (m_ctl[4]) return {m_ctl[3], m_ctl[2], m_ctl[0], m_ctl[1]};
        return pins;
    endfunction

    // Apply one level step to the model
    task automatic model_step();
        logic [3:0] nl;
        nl = eff_lvl();
        m_dlt[0] |= nl[0] ^ m_lvl[0];
        m_dlt[1] |= nl[1] ^ m_lvl[1];
        m_dlt[2] |= m_lvl[2] & ~nl[2];
        m_dlt[3] |= nl[3] ^ m_lvl[3];
        m_lvl = nl;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic wr_ctl(logic [7:0] v);
        @(negedge clk);
        ctl_wr = 1'b1; ctl_wdata = v;
        @(negedge clk);
        ctl_wr = 1'b0;
        m_ctl = v[4:0];
    endtask

    task automatic set_pins(logic [3:0] v);
        @(negedge clk);
        pins = v;
    endtask

    // Driver: pushes expected status and pulses the read strobe
    task automatic rd_sts(string req);
        @(negedge clk);
        sts_rd = 1'b1;
        exp_q.push_back({m_lvl, m_dlt});
        tag_q.push_back(req);
        m_dlt = '0;
        @(negedge clk);
        sts_rd = 1'b0;
    endtask

    // Monitor: compares each read result against the queue
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (sts_rd) begin
                if (exp_q.size() == 0) begin
                    chk("R4 unexpected read", sts_rdata, 8'h00);
                end else begin
                    logic [7:0] e;
                    string      t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    chk(t, sts_rdata, e);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        // reset state
        chk("R1 reset ctl", ctl_rdata, 8'h00);
        chk("R4 reset status", sts_rdata, 8'h00);
        chk("R8 reset req", {7'b0, msc_req}, 8'h00);
        chk("R2 reset outputs", {4'b0, mdm_aux2, mdm_aux1, mdm_rts, mdm_dtr}, 8'h00);

        // R1 / R2 readback and pin drive
        wr_ctl(8'hEF);
        #1;
        chk("R1 readback upper zero", ctl_rdata, 8'h0F);
        chk("R2 outputs follow", {4'b0, mdm_aux2, mdm_aux1, mdm_rts, mdm_dtr}, 8'h0F);
        port_irq = 1'b1;
        #1;
        chk("R3 irq passes with aux2", {7'b0, host_irq}, 8'h01);
        wr_ctl(8'h05);
        #1;
        chk("R2 outputs pattern", {4'b0, mdm_aux2, mdm_aux1, mdm_rts, mdm_dtr}, 8'h05);
        chk("R3 irq blocked without aux2", {7'b0, host_irq}, 8'h00);

        // R10 normal serial path
        tx_ser = 1'b0; ser_rxd = 1'b1;
        #1;
        chk("R10 normal txd", {7'b0, ser_txd}, 8'h00);
        chk("R10 normal rx", {7'b0, rx_ser}, 8'h01);

        // R4 / R5 cts rise
        set_pins(4'b0001); model_step(); settle();
        chk("R8 req raised", {7'b0, msc_req}, 8'h01);
        rd_sts("R4 R5 cts rise");
        #1;
        chk("R7 req cleared by read", {7'b0, msc_req}, 8'h00);

        // R6 ring rise gives no flag, fall does
        set_pins(4'b0101); model_step(); settle();
        chk("R6 ring rise no req", {7'b0, msc_req}, 8'h00);
        rd_sts("R6 ring rise");
        set_pins(4'b0001); model_step(); settle();
        rd_sts("R6 ring fall");

        // R5 sticky: dsr+dcd rise, then dcd fall, no read between
        set_pins(4'b1011); model_step(); settle();
        set_pins(4'b0011); model_step(); settle();
        rd_sts("R5 sticky flags");
        rd_sts("R7 flags cleared");

        // R7 change lands on the read edge
        set_pins(4'b0001);
        @(negedge clk);
        rd_sts("R7 read before change");
        model_step();
        settle();
        rd_sts("R7 same-edge change kept");

        // R9 / R10 loopback
        wr_ctl(8'h1A);             // loop, aux2, rts
        model_step(); settle();
        #1;
        chk("R10 loop outputs idle", {3'b0, ser_txd, mdm_aux2, mdm_aux1, mdm_rts, mdm_dtr}, 8'h10);
        chk("R10 loop rx follows tx", {7'b0, rx_ser}, {7'b0, tx_ser});
        tx_ser = 1'b1;
        #1;
        chk("R10 loop rx follows tx high", {7'b0, rx_ser}, 8'h01);
        chk("R3 irq in loopback", {7'b0, host_irq}, 8'h01);
        rd_sts("R9 loop mapping");
        set_pins(4'b1110); settle();
        rd_sts("R9 pins ignored");
        wr_ctl(8'h15);             // loop, aux1, dtr
        model_step(); settle();
        rd_sts("R9 remap dtr aux1");

        // leave loopback
        wr_ctl(8'h00);
        model_step(); settle();
        rd_sts("R4 back to pins");

        settle();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule